// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one external bus cycle at a time for a processor whose address and data share the same pins. A request supplies a 20-bit address, write data, a byte or word size, a memory or I/O selection, a direction and a 2-bit segment code. The sequencer then steps through four bus clocks. In the first clock the shared pins carry the address and a strobe pulse tells external logic to latch it. In the later clocks the same pins carry write data or are released for read data, and the four upper lines carry status.

Wait states are inserted while the ready input is low at the end of the third clock. For reads, the data on the shared bus is captured at the end of the last third clock. It is then returned aligned to the low byte for byte accesses. The shared bus is modelled as a separate output, output enable and input, so that a pad ring can build the tristate.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the bus is idle: `ad_oe`=0, `ale`=0, `rd_n`=1, `wr_n`=1, `bhe_n`=1, `a_hi`=0 and `req_ready`=1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The first bus clock (T1) follows in the next cycle. `req_ready` stays low from T1 through T4 and returns high in the cycle after T4.
- R3: In T1, `ale`=1, `ad_oe`=1 and `ad_out` equals address bits 15..0. `a_hi` equals address bits 19..16 for memory cycles and 0 for I/O cycles, since ports span only 16 bits. `ale` is low in every other clock.
- R4: In T2, T3 and T4, `a_hi` carries status. Bit 3 is constant 0. Bit 2 is the live `int_en` input. Bits 1:0 are the segment code: 00 extra, 01 stack, 10 code or none, 11 data.
- R5: In T1, `bhe_n` is 0 for a word access or for a byte access at an odd address, and 1 for a byte access at an even address. In T2 to T4 the pin carries status bit 7, held at 1.
- R6: From T1 to T4, `m_io` is 1 for memory and 0 for I/O cycles. Over the same clocks, `dt_r` is 1 for writes and 0 for reads. In idle, `m_io`=0 and `dt_r`=1.
- R7: For writes in T2, T3 and T4, `ad_oe`=1. `ad_out` holds the full word for word writes, or `req_wdata[7:0]` copied onto both byte lanes for byte writes. `wr_n` is 0 in T2 and T3 and 1 in T4.
- R8: For reads, `ad_oe`=0 in T2, T3 and T4. `rd_n` is 0 in T2 and T3 and 1 in T4. `rd_n` and `wr_n` are never low together.
- R9: If `ready` is low at the end of a T3 clock, another T3 follows with all outputs unchanged. T4 follows the first T3 that ends with `ready` high.
- R10: Read data is taken from `ad_in` at the end of the last T3. `rdata_valid` is high for exactly the T4 clock of a read cycle. `rdata` is then `ad_in` for words, `{8'h00, ad_in[7:0]}` for even-address bytes and `{8'h00, ad_in[15:8]}` for odd-address bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 20 | Physical memory address or port number |
| req_wdata | input | 16 | Write data (byte writes use bits 7..0) |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_write | input | 1 | 1 = write, 0 = read |
| req_seg | input | 2 | Segment code placed on status bits 1:0 |
| int_en | input | 1 | Interrupt-enable flag shown on status bit 2 |
| ready | input | 1 | Ends wait states when high at the end of T3 |
| ad_out | output | 16 | Shared address/data bus, driven value |
| ad_oe | output | 1 | Shared bus drive enable |
| ad_in | input | 16 | Shared address/data bus, received value |
| a_hi | output | 4 | Upper address lines / status |
| ale | output | 1 | Address latch pulse, high in T1 |
| bhe_n | output | 1 | High byte lane enable, active low / status bit 7 |
| m_io | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| dt_r | output | 1 | 1 = transmit (write), 0 = receive (read) |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdata | output | 16 | Captured read data, lane-aligned |
| rdata_valid | output | 1 | `rdata` updated, high in T4 of a read |

## Verification
The assertions assume that `ready` is a clean level sampled only at clock edges, and that `req_valid` is raised only while the requester can see `req_ready`. They also assume that word requests use an even address, since no bus-splitting of odd word accesses is modelled. The stimulus drives every input on the falling clock edge. It issues only even-address word requests, holds `ready` low solely in the T3 clocks it means to stretch, and changes `int_en` only between cycles.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int BYTE_W = DATA_W / 2;
  localparam int HI_W   = ADDR_W - DATA_W;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } phase_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              word;
    logic              mem;
    logic              write;
    logic [1:0]        seg;
  } bus_req_t;

  // Active-low high-lane enable for the address phase.
  function automatic logic hi_lane_n(input logic word, input logic a0);
    return !(word || a0);
  endfunction

  // Status nibble for the data phase: constant 0, interrupt flag, segment.
  function automatic logic [HI_W-1:0] status_nib(input logic ie, input logic [1:0] seg);
    return {1'b0, ie, seg};
  endfunction

  // Place write data on the lanes; bytes go to both halves.
  function automatic logic [DATA_W-1:0] lane_wdata(input logic word,
                                                   input logic [DATA_W-1:0] d);
    return word ? d : {d[BYTE_W-1:0], d[BYTE_W-1:0]};
  endfunction

  // Pick the addressed lane of a read and align it low.
  function automatic logic [DATA_W-1:0] lane_rdata(input logic word, input logic a0,
                                                   input logic [DATA_W-1:0] d);
    if (word)    return d;
    else if (a0) return {{BYTE_W{1'b0}}, d[DATA_W-1:BYTE_W]};
    else         return {{BYTE_W{1'b0}}, d[BYTE_W-1:0]};
  endfunction

endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   ready,
  output phase_t phase,
  output logic   idle,
  output logic   last_t3
);

  phase_t phase_nx;

  assign idle    = (phase == PH_IDLE);
  assign last_t3 = (phase == PH_T3) && ready;

  always_comb begin
    phase_nx = PH_IDLE;
    unique case (phase)
      PH_IDLE: phase_nx = start ? PH_T1 : PH_IDLE;
      PH_T1:   phase_nx = PH_T2;
      PH_T2:   phase_nx = PH_T3;
      PH_T3:   phase_nx = ready ? PH_T4 : PH_T3;
      PH_T4:   phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  // R2: an accepted request opens T1 on the next clock
  a_r2_start_to_t1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase == PH_T1));

  // R9: a low ready at the end of T3 repeats T3
  a_r9_wait_holds_t3: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_T3) && !ready) |=> (phase == PH_T3));

  // R2: the cycle after T4 is idle again
  a_r2_t4_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T4) |=> idle);

endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
  import bus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  bus_req_t          req,
  input  logic              int_en,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   a_hi,
  output logic              ale,
  output logic              bhe_n,
  output logic              m_io,
  output logic              dt_r,
  output logic              rd_n,
  output logic              wr_n
);

  logic data_phase;
  assign data_phase = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_T4);

  always_comb begin
    ad_out = '0;
    ad_oe  = 1'b0;
    a_hi   = '0;
    ale    = 1'b0;
    bhe_n  = 1'b1;
    m_io   = 1'b0;
    dt_r   = 1'b1;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    if (phase == PH_T1) begin
      ad_out = req.addr[DATA_W-1:0];
      ad_oe  = 1'b1;
      a_hi   = req.mem ? req.addr[ADDR_W-1:DATA_W] : '0;
      ale    = 1'b1;
      bhe_n  = hi_lane_n(req.word, req.addr[0]);
      m_io   = req.mem;
      dt_r   = req.write;
    end else if (data_phase) begin
      a_hi = status_nib(int_en, req.seg);
      m_io = req.mem;
      dt_r = req.write;
      if (req.write) begin
        ad_out = lane_wdata(req.word, req.wdata);
        ad_oe  = 1'b1;
        wr_n   = (phase == PH_T4);
      end else begin
        rd_n   = (phase == PH_T4);
      end
    end
  end

  // R3: address latch strobe is a single-clock pulse
  a_r3_ale_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R8: bus released whenever the read strobe is active
  a_r8_read_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R8: never both strobes
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R6: cycle type and direction stay fixed after T1
  a_r6_type_stable: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |-> ($stable(m_io) && $stable(dt_r)));

  // R4: status bit 3 is low while a strobe is active
  a_r4_s6_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !a_hi[HI_W-1]);

endmodule

// File: rtl/bus_seq_capture.sv
module bus_seq_capture
  import bus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_t3,
  input  logic              is_write,
  input  logic              is_word,
  input  logic              a0,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid
);

  logic take;
  assign take = last_t3 && !is_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= take;
      if (take) rdata <= lane_rdata(is_word, a0, ad_in);
    end
  end

  // R10: read data valid lasts one clock
  a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> !rdata_valid);

  // R10: returned data holds between captures
  a_r10_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(take) |-> $stable(rdata));

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import bus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_word,
  input  logic              req_mem,
  input  logic              req_write,
  input  logic [1:0]        req_seg,
  input  logic              int_en,
  input  logic              ready,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   a_hi,
  output logic              ale,
  output logic              bhe_n,
  output logic              m_io,
  output logic              dt_r,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid
);

  phase_t   phase;
  logic     idle;
  logic     last_t3;
  logic     start;
  bus_req_t cur;

  assign req_ready = idle;
  assign start     = req_valid && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else if (start) cur <= '{addr: req_addr, wdata: req_wdata, word: req_word,
                             mem: req_mem, write: req_write, seg: req_seg};
  end

  bus_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .ready   (ready),
    .phase   (phase),
    .idle    (idle),
    .last_t3 (last_t3)
  );

  bus_seq_drive u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .req    (cur),
    .int_en (int_en),
    .ad_out (ad_out),
    .ad_oe  (ad_oe),
    .a_hi   (a_hi),
    .ale    (ale),
    .bhe_n  (bhe_n),
    .m_io   (m_io),
    .dt_r   (dt_r),
    .rd_n   (rd_n),
    .wr_n   (wr_n)
  );

  bus_seq_capture u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .last_t3     (last_t3),
    .is_write    (cur.write),
    .is_word     (cur.word),
    .a0          (cur.addr[0]),
    .ad_in       (ad_in),
    .rdata       (rdata),
    .rdata_valid (rdata_valid)
  );

  // R2: no new request is taken while a cycle runs
  a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !req_ready);

endmodule

// File: tb/mux_bus_seq_bench.sv
`timescale 1ns/1ps
module mux_bus_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_word = 1'b0;
  logic        req_mem = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_seg = '0;
  logic        int_en = 1'b0;
  logic        ready = 1'b1;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [15:0] ad_in = '0;
  logic [3:0]  a_hi;
  logic        ale, bhe_n, m_io, dt_r, rd_n, wr_n;
  logic [15:0] rdata;
  logic        rdata_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  mux_bus_seq u_mux_bus_seq (.*);

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever the design reports read data (R10)
  always @(negedge clk) begin
    if (rst_n && rdata_valid) begin
      if (exp_q.size() == 0) chk("R10 unexpected rdata_valid", 20'd1, 20'd0);
      else chk("R10 read data", {4'h0, rdata}, {4'h0, exp_q.pop_front()});
    end
  end

  task automatic bus_cycle(input logic [19:0] addr, input logic [15:0] wd,
                           input logic word, input logic mem, input logic wr,
                           input logic [1:0] seg, input int nwait,
                           input logic [15:0] bus_rd);
    logic [3:0]  st;
    logic        hb;
    logic [15:0] lanes;
    logic [15:0] rexp;
    st = {1'b0, int_en, seg};
    case ({word, addr[0]})
      2'b00:   hb = 1'b1;
      default: hb = 1'b0;
    endcase
    lanes = word ? wd : {2{wd[7:0]}};
    if (word)         rexp = bus_rd;
    else if (addr[0]) rexp = {8'h00, bus_rd[15:8]};
    else              rexp = {8'h00, bus_rd[7:0]};
    chk("R2 ready before request", {19'd0, req_ready}, 20'd1);
    req_addr = addr; req_wdata = wd; req_word = word; req_mem = mem;
    req_write = wr; req_seg = seg; req_valid = 1'b1;
    if (!wr) exp_q.push_back(rexp);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~addr; req_wdata = ~wd;
    ad_in = 16'hBAD0;
    // T1
    chk("R3 ale in T1", {19'd0, ale}, 20'd1);
    chk("R3 ad_oe in T1", {19'd0, ad_oe}, 20'd1);
    chk("R3 address low", {4'h0, ad_out}, {4'h0, addr[15:0]});
    chk("R3 address high", {16'h0, a_hi}, mem ? {16'h0, addr[19:16]} : 20'd0);
    chk("R5 bhe_n in T1", {19'd0, bhe_n}, {19'd0, hb});
    chk("R6 m_io", {19'd0, m_io}, {19'd0, mem});
    chk("R6 dt_r", {19'd0, dt_r}, {19'd0, wr});
    chk("R2 busy in T1", {19'd0, req_ready}, 20'd0);
    @(negedge clk);
    // T2, then T3 repeated nwait extra times
    for (int k = 0; k <= nwait + 1; k++) begin
      chk("R4 status", {16'h0, a_hi}, {16'h0, st});
      chk("R3 ale low", {19'd0, ale}, 20'd0);
      chk("R5 S7 held", {19'd0, bhe_n}, 20'd1);
      chk("R6 dt_r held", {19'd0, dt_r}, {19'd0, wr});
      if (wr) begin
        chk("R7 write drive", {19'd0, ad_oe}, 20'd1);
        chk("R7 write data", {4'h0, ad_out}, {4'h0, lanes});
        chk("R7 wr_n low", {18'd0, wr_n, rd_n}, 20'd1);
      end else begin
        chk("R8 bus released", {19'd0, ad_oe}, 20'd0);
        chk("R8 rd_n low", {18'd0, wr_n, rd_n}, 20'd2);
      end
      chk("R9 no early data", {19'd0, rdata_valid}, 20'd0);
      if (k >= 1) begin
        ready = (k == nwait + 1);
        ad_in = (k == nwait + 1) ? bus_rd : 16'hBAD0 + 16'(k);
      end
      @(negedge clk);
    end
    // T4
    ready = 1'b1;
    chk("R9 T4 strobes released", {18'd0, wr_n, rd_n}, 20'd3);
    chk("R4 status in T4", {16'h0, a_hi}, {16'h0, st});
    if (wr) chk("R7 data held in T4", {4'h0, ad_out}, {4'h0, lanes});
    else    chk("R8 released in T4", {19'd0, ad_oe}, 20'd0);
    chk("R10 valid in T4", {19'd0, rdata_valid}, {19'd0, !wr});
    chk("R2 busy in T4", {19'd0, req_ready}, 20'd0);
    @(negedge clk);
    chk("R2 idle after T4", {19'd0, req_ready}, 20'd1);
    chk("R6 idle type", {18'd0, m_io, dt_r}, 20'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset drive", {19'd0, ad_oe}, 20'd0);
    chk("R1 reset ale", {19'd0, ale}, 20'd0);
    chk("R1 reset strobes", {17'd0, bhe_n, wr_n, rd_n}, 20'd7);
    chk("R1 reset a_hi", {16'h0, a_hi}, 20'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {19'd0, req_ready}, 20'd1);

    bus_cycle(20'hA1234, 16'h0000, 1'b1, 1'b1, 1'b0, 2'b11, 0, 16'hC3A5);
    int_en = 1'b1;
    bus_cycle(20'h5BEEF, 16'h77E1, 1'b0, 1'b1, 1'b1, 2'b00, 0, 16'h0);
    bus_cycle(20'h3F001, 16'h0000, 1'b0, 1'b1, 1'b0, 2'b01, 2, 16'h9A5C);
    int_en = 1'b0;
    bus_cycle(20'h3F002, 16'h0000, 1'b0, 1'b1, 1'b0, 2'b10, 1, 16'h9A5C);
    bus_cycle(20'hF1234, 16'hCAFE, 1'b1, 1'b0, 1'b1, 2'b10, 3, 16'h0);
    int_en = 1'b1;
    bus_cycle(20'h8007E, 16'h0000, 1'b1, 1'b0, 1'b0, 2'b11, 1, 16'h1E2D);
    bus_cycle(20'h00000, 16'h4455, 1'b0, 1'b1, 1'b1, 2'b01, 0, 16'h0);

    repeat (2) @(negedge clk);
    chk("R10 scoreboard drained", 20'(exp_q.size()), 20'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule